// File: doc/BRIEF.md
# Enhanced Parallel Port Cycle Controller

This block sits between a host register interface and an 8-bit parallel peripheral bus. It turns each host access to the port's address or data register into one handshaked bus cycle. The controller drives the data strobe, the address strobe, the write line and the bus output enable. It holds a host ready line low while the cycle runs, and it paces every phase on a peripheral wait input that is synchronised through two flops. A write waits for the wait line to go low, puts the byte on the bus and then pulses the matching strobe. When the wait line goes high the strobe is released and the host is let go. The write line and the bus byte stay held until the peripheral pulls wait low again.

A watchdog bounds each cycle to 10 µs of clock time, counted from acceptance until the wait line rises. On expiry the cycle is aborted and a sticky timeout status bit is set. An active STROBE control bit during a cycle forces the bus into output mode. A write issued while the direction bit is set is carried out as a read-style cycle, with no error. When no cycle is running, the strobe, autofeed and init pins and the bus direction follow the standard-port control bits.

Top module: `epp_cycle_ctrl`

## Requirements
- R1: After reset, host_rdy is 1, port_dstb_n, port_astb_n and port_write_n are 1, and stat_timeout is 0.
- R2: A single-cycle pulse on host_wr or host_rd, taken while host_rdy is 1, drives host_rdy to 0 on the next clock. host_rdy stays 0 until the cycle terminates or is aborted. host_wr has priority if both are set.
- R3: A write with ctl_dir=0 waits for the synchronised port_wait_n to be 0. It then drives host_wdata on port_dout with port_oe=1 and port_write_n=0. After that it asserts port_dstb_n=0 when host_sel_addr=0, or port_astb_n=0 when host_sel_addr=1.
- R4: When the synchronised port_wait_n goes to 1 during a strobe, the strobe is released and host_rdy returns to 1. port_write_n and port_dout keep their values at least until the strobe has been released.
- R5: A read (host_rd) always uses port_dstb_n, never port_astb_n. It keeps port_write_n=1 and port_oe=0, and loads host_rdata with port_din at termination.
- R6: If a cycle has not seen port_wait_n rise within WD_CYC = CLK_HZ/100000 clocks after acceptance (500 at 50 MHz), it is aborted. In the same clock both strobes go to 1, host_rdy goes to 1 and stat_timeout goes to 1.
- R7: stat_timeout is sticky and is cleared one clock after a stat_rd pulse.
- R8: While ctl_strobe=1 during a cycle, port_oe=1 and port_write_n=0, whatever the cycle type.
- R9: A write issued with ctl_dir=1 runs as a read-style cycle: port_oe=0, port_write_n=1, host_rdata is loaded from port_din, and stat_timeout stays 0.
- R10: With no cycle active, port_strobe_n, port_autofd_n and port_init_n are the inverses of ctl_strobe, ctl_autofd and ctl_init, port_oe equals the inverse of ctl_dir, and port_write_n is 1.
- R11: port_dstb_n and port_astb_n are never 0 at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_sel_addr | input | 1 | 1 selects the address register, 0 the data register |
| host_wr | input | 1 | Write request pulse |
| host_rd | input | 1 | Read request pulse |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Byte captured from the port on a read |
| host_rdy | output | 1 | High when the host may proceed |
| stat_rd | input | 1 | Status read pulse; clears the timeout bit |
| stat_timeout | output | 1 | Sticky watchdog timeout status (bit 0) |
| ctl_strobe | input | 1 | Standard control: strobe asserted |
| ctl_autofd | input | 1 | Standard control: autofeed asserted |
| ctl_init | input | 1 | Standard control: init asserted |
| ctl_dir | input | 1 | Standard control: 1 = bus input direction |
| port_wait_n | input | 1 | Peripheral wait line, asynchronous |
| port_din | input | 8 | Bus byte from the peripheral |
| port_dout | output | 8 | Bus byte to the peripheral |
| port_oe | output | 1 | 1 = controller drives the bus |
| port_write_n | output | 1 | Active-low write line |
| port_dstb_n | output | 1 | Active-low data strobe |
| port_astb_n | output | 1 | Active-low address strobe |
| port_strobe_n | output | 1 | Active-low strobe pin |
| port_autofd_n | output | 1 | Active-low autofeed pin |
| port_init_n | output | 1 | Active-low init pin |

## Verification
The peripheral model answers with random delays. It records the write line, the output enable, the bus byte and which strobe fell at the moment a strobe goes low, and it checks that the write line and the byte are still held when the strobe is released. A design that strobed the wrong register, or changed the byte before the acknowledge, would fail there. Two stalls are driven on purpose: one with wait never asserted and one with the strobe stuck waiting for wait to rise. A watchdog counting from the wrong point, or an abort that leaves a strobe low or the host stalled, shows up as a release outside the expected window. Writes with the direction bit set must come out as reads with no timeout flag, and reads with STROBE held must drive the bus. A controller that let a set direction bit through, or ignored the override, fails those checks.

// File: rtl/epp_pkg.sv
package epp_pkg;

  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_ARM   = 3'd1,
    S_SETUP = 3'd2,
    S_STB   = 3'd3,
    S_ACK   = 3'd4
  } epp_st_e;

  // clocks in a 10 us window, never below 2
  function automatic int unsigned wd_limit(input int unsigned clk_hz);
    int unsigned n;
    n = clk_hz / 100000;
    return (n < 2) ? 2 : n;
  endfunction

endpackage

// File: rtl/epp_wait_sync.sv
module epp_wait_sync #(
  parameter bit RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= RST_VAL;
      q    <= RST_VAL;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/epp_watchdog.sv
module epp_watchdog #(
  parameter int unsigned LIMIT = 500,
  localparam int unsigned CW = $clog2(LIMIT + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          run,
  output logic          expire,
  output logic [CW-1:0] count
);
  assign expire = run && (count == CW'(LIMIT - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
    end else if (start) begin
      count <= '0;
    end else if (run && !expire) begin
      count <= count + 1'b1;
    end
  end
endmodule

// File: rtl/epp_seq.sv
module epp_seq
  import epp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_wr,
  input  logic       req_rd,
  input  logic       req_sel,
  input  logic [7:0] wdata,
  input  logic       dir,
  input  logic       wait_s,
  input  logic [7:0] din,
  input  logic       wd_expire,
  output epp_st_e    st,
  output logic       accept,
  output logic       drv_wr,
  output logic       cyc_addr,
  output logic [7:0] dout,
  output logic [7:0] rdata
);
  logic       cyc_wr;
  logic [7:0] wlatch;
  logic       slot_free;

  assign slot_free = (st == S_IDLE) || (st == S_ACK);
  assign accept    = slot_free && (req_wr || req_rd);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      cyc_wr   <= 1'b0;
      cyc_addr <= 1'b0;
      wlatch   <= '0;
      drv_wr   <= 1'b0;
      dout     <= '0;
      rdata    <= '0;
    end else if (accept) begin
      st       <= S_ARM;
      cyc_wr   <= req_wr && !dir;
      cyc_addr <= req_wr && req_sel;
      wlatch   <= wdata;
    end else begin
      unique case (st)
        S_IDLE: ;
        S_ARM: begin
          if (wd_expire) begin
            st     <= S_IDLE;
            drv_wr <= 1'b0;
          end else if (!wait_s) begin
            st     <= S_SETUP;
            drv_wr <= cyc_wr;
            if (cyc_wr) dout <= wlatch;
          end
        end
        S_SETUP: begin
          if (wd_expire) begin
            st     <= S_IDLE;
            drv_wr <= 1'b0;
          end else begin
            st <= S_STB;
          end
        end
        S_STB: begin
          if (wd_expire) begin
            st     <= S_IDLE;
            drv_wr <= 1'b0;
          end else if (wait_s) begin
            st <= S_ACK;
            if (!cyc_wr) rdata <= din;
          end
        end
        S_ACK: begin
          if (!wait_s) begin
            st     <= S_IDLE;
            drv_wr <= 1'b0;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/epp_cycle_ctrl.sv
module epp_cycle_ctrl
  import epp_pkg::*;
#(
  parameter int unsigned CLK_HZ = 50_000_000,
  localparam int unsigned WD_CYC = wd_limit(CLK_HZ),
  localparam int unsigned WD_CW  = $clog2(WD_CYC + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       host_sel_addr,
  input  logic       host_wr,
  input  logic       host_rd,
  input  logic [7:0] host_wdata,
  output logic [7:0] host_rdata,
  output logic       host_rdy,
  input  logic       stat_rd,
  output logic       stat_timeout,
  input  logic       ctl_strobe,
  input  logic       ctl_autofd,
  input  logic       ctl_init,
  input  logic       ctl_dir,
  input  logic       port_wait_n,
  input  logic [7:0] port_din,
  output logic [7:0] port_dout,
  output logic       port_oe,
  output logic       port_write_n,
  output logic       port_dstb_n,
  output logic       port_astb_n,
  output logic       port_strobe_n,
  output logic       port_autofd_n,
  output logic       port_init_n
);
  epp_st_e          st;
  logic             wait_sync;
  logic             accept;
  logic             drv_wr;
  logic             cyc_addr;
  logic             wd_expire;
  logic             wd_run;
  logic [WD_CW-1:0] wd_count;
  logic             cyc_active;
  logic             stb_on;

  epp_wait_sync #(.RST_VAL(1'b1)) sync_i (
    .clk(clk), .rst_n(rst_n), .d(port_wait_n), .q(wait_sync)
  );

  assign wd_run = (st == S_ARM) || (st == S_SETUP) || (st == S_STB);

  epp_watchdog #(.LIMIT(WD_CYC)) wd_i (
    .clk(clk), .rst_n(rst_n), .start(accept), .run(wd_run),
    .expire(wd_expire), .count(wd_count)
  );

  epp_seq seq_i (
    .clk(clk), .rst_n(rst_n),
    .req_wr(host_wr), .req_rd(host_rd), .req_sel(host_sel_addr),
    .wdata(host_wdata), .dir(ctl_dir), .wait_s(wait_sync),
    .din(port_din), .wd_expire(wd_expire),
    .st(st), .accept(accept), .drv_wr(drv_wr), .cyc_addr(cyc_addr),
    .dout(port_dout), .rdata(host_rdata)
  );

  assign cyc_active = (st != S_IDLE);
  assign stb_on     = (st == S_STB);

  assign host_rdy     = (st == S_IDLE) || (st == S_ACK);
  assign port_dstb_n  = !(stb_on && !cyc_addr);
  assign port_astb_n  = !(stb_on && cyc_addr);
  assign port_oe      = cyc_active ? (drv_wr || ctl_strobe) : !ctl_dir;
  assign port_write_n = !(drv_wr || (cyc_active && ctl_strobe));

  assign port_strobe_n = !ctl_strobe;
  assign port_autofd_n = !ctl_autofd;
  assign port_init_n   = !ctl_init;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_timeout <= 1'b0;
    end else if (wd_expire) begin
      stat_timeout <= 1'b1;
    end else if (stat_rd) begin
      stat_timeout <= 1'b0;
    end
  end
endmodule

// File: rtl/epp_cycle_ctrl_chk.sv
module epp_cycle_ctrl_chk #(
  parameter int unsigned LIMIT = 500,
  parameter int unsigned CW = 9
) (
  input logic          clk,
  input logic          rst_n,
  input logic          host_rdy,
  input logic          port_dstb_n,
  input logic          port_astb_n,
  input logic          port_write_n,
  input logic          port_oe,
  input logic [7:0]    port_dout,
  input logic          stat_timeout,
  input logic          wd_expire,
  input logic [CW-1:0] wd_count
);
  // R11
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!port_dstb_n && !port_astb_n));

  // R2
  rdy_low_in_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!port_dstb_n || !port_astb_n) |-> !host_rdy);

  // R6
  abort_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wd_expire |=> (stat_timeout && host_rdy && port_dstb_n && port_astb_n));

  // R6
  wd_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wd_count < CW'(LIMIT));

  // R8
  write_drives_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !port_write_n |-> port_oe);

  // R4
  data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!port_dstb_n && !port_write_n && $past(!port_dstb_n)) |-> $stable(port_dout));
endmodule

bind epp_cycle_ctrl epp_cycle_ctrl_chk #(.LIMIT(WD_CYC), .CW(WD_CW)) chk_i (
  .clk(clk), .rst_n(rst_n), .host_rdy(host_rdy),
  .port_dstb_n(port_dstb_n), .port_astb_n(port_astb_n),
  .port_write_n(port_write_n), .port_oe(port_oe), .port_dout(port_dout),
  .stat_timeout(stat_timeout), .wd_expire(wd_expire), .wd_count(wd_count)
);

// File: tb/epp_cycle_ctrl_tb_top.sv
module epp_cycle_ctrl_tb_top;
  localparam int unsigned HZ = 50_000_000;
  localparam int WD = HZ / 100000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic host_sel_addr = 0, host_wr = 0, host_rd = 0, stat_rd = 0;
  logic [7:0] host_wdata = '0, host_rdata;
  logic host_rdy, stat_timeout;
  logic ctl_strobe = 0, ctl_autofd = 0, ctl_init = 0, ctl_dir = 0;
  logic port_wait_n = 1'b0;
  logic [7:0] port_din = '0, port_dout;
  logic port_oe, port_write_n, port_dstb_n, port_astb_n;
  logic port_strobe_n, port_autofd_n, port_init_n;

  int errs = 0;
  int checks = 0;
  bit done = 0;

  always #10 clk = ~clk;

  epp_cycle_ctrl #(.CLK_HZ(HZ)) dut_i (
    .clk(clk), .rst_n(rst_n), .host_sel_addr(host_sel_addr),
    .host_wr(host_wr), .host_rd(host_rd), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .host_rdy(host_rdy), .stat_rd(stat_rd),
    .stat_timeout(stat_timeout), .ctl_strobe(ctl_strobe),
    .ctl_autofd(ctl_autofd), .ctl_init(ctl_init), .ctl_dir(ctl_dir),
    .port_wait_n(port_wait_n), .port_din(port_din), .port_dout(port_dout),
    .port_oe(port_oe), .port_write_n(port_write_n),
    .port_dstb_n(port_dstb_n), .port_astb_n(port_astb_n),
    .port_strobe_n(port_strobe_n), .port_autofd_n(port_autofd_n),
    .port_init_n(port_init_n)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  // expected bus drive during a cycle
  function automatic bit exp_drive(input bit wr, input bit dir, input bit stb);
    return (wr && !dir) || stb;
  endfunction

  // peripheral model
  bit periph_en = 1;
  bit p_seen, p_addr, p_wn, p_oe, p_hold;
  bit [7:0] p_dout, p_rval;

  initial begin
    forever begin
      @(negedge clk);
      if (periph_en && (!port_dstb_n || !port_astb_n)) begin
        p_seen = 1;
        p_addr = !port_astb_n;
        p_wn   = port_write_n;
        p_oe   = port_oe;
        p_dout = port_dout;
        p_rval = 8'($urandom);
        port_din = p_rval;
        repeat ($urandom_range(3, 0)) @(negedge clk);
        port_wait_n = 1'b1;
        while (!port_dstb_n || !port_astb_n) @(negedge clk);
        p_hold = (port_write_n == p_wn) && (port_dout == p_dout);
        repeat ($urandom_range(3, 0)) @(negedge clk);
        port_wait_n = 1'b0;
      end
    end
  end

  task automatic wait_rdy(output int k);
    k = 0;
    while (!host_rdy && k < 3000) begin
      @(negedge clk);
      k++;
    end
  endtask

  task automatic do_cyc(input bit wr, input bit sel, input bit [7:0] d);
    int k;
    bit eff_wr;
    p_seen = 0;
    p_hold = 0;
    @(negedge clk);
    host_wr = wr; host_rd = !wr; host_sel_addr = sel; host_wdata = d;
    @(negedge clk);
    host_wr = 0; host_rd = 0;
    chk("R2", "host_rdy low after request", int'(host_rdy), 0);
    wait_rdy(k);
    eff_wr = wr && !ctl_dir;
    chk("R2", "host_rdy released", int'(host_rdy), 1);
    chk("R3", "strobe seen", int'(p_seen), 1);
    // R3 R5: address strobe only for address writes
    chk("R5", "strobe kind addr", int'(p_addr), int'(wr && sel));
    chk("R8", "oe during strobe", int'(p_oe), int'(exp_drive(wr, ctl_dir, ctl_strobe)));
    chk("R8", "write_n during strobe", int'(p_wn), int'(!exp_drive(wr, ctl_dir, ctl_strobe)));
    chk("R4", "write_n/data held to strobe release", int'(p_hold), 1);
    if (eff_wr) chk("R3", "bus byte", int'(p_dout), int'(d));
    else        chk("R9", "read byte captured", int'(host_rdata), int'(p_rval));
    chk("R9", "no timeout flag", int'(stat_timeout), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errs++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      report();
    end
  end

  initial begin
    int k;
    process::self().srandom(32'd1234);
    repeat (3) @(negedge clk);
    // R1
    chk("R1", "reset host_rdy", int'(host_rdy), 1);
    chk("R1", "reset dstb_n", int'(port_dstb_n), 1);
    chk("R1", "reset astb_n", int'(port_astb_n), 1);
    chk("R1", "reset write_n", int'(port_write_n), 1);
    chk("R1", "reset stat", int'(stat_timeout), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R10 idle pin following
    for (int i = 0; i < 8; i++) begin
      ctl_strobe = i[0]; ctl_autofd = i[1]; ctl_init = i[2]; ctl_dir = ~i[0];
      @(negedge clk);
      chk("R10", "strobe pin", int'(port_strobe_n), int'(!i[0]));
      chk("R10", "autofd pin", int'(port_autofd_n), int'(!i[1]));
      chk("R10", "init pin", int'(port_init_n), int'(!i[2]));
      chk("R10", "idle oe", int'(port_oe), int'(i[0]));
      chk("R10", "idle write_n", int'(port_write_n), 1);
    end
    ctl_strobe = 0; ctl_autofd = 0; ctl_init = 0; ctl_dir = 0;

    // directed R3 R5
    do_cyc(1, 0, 8'h5A);
    do_cyc(1, 1, 8'hA5);
    do_cyc(0, 0, 8'h00);
    do_cyc(0, 1, 8'hFF);

    // R9 direction bit set on writes
    ctl_dir = 1;
    do_cyc(1, 0, 8'h3C);
    do_cyc(1, 1, 8'hC3);
    ctl_dir = 0;

    // R8 strobe override on reads
    ctl_strobe = 1;
    do_cyc(0, 0, 8'h11);
    do_cyc(1, 1, 8'h22);
    ctl_strobe = 0;

    // random mix
    for (int i = 0; i < 40; i++) begin
      ctl_dir = ($urandom_range(3, 0) == 0);
      ctl_strobe = ($urandom_range(7, 0) == 0);
      do_cyc(1'($urandom), 1'($urandom), 8'($urandom));
    end
    ctl_dir = 0; ctl_strobe = 0;
    repeat (12) @(negedge clk);

    // R6: wait never asserted
    periph_en = 0;
    port_wait_n = 1'b1;
    repeat (4) @(negedge clk);
    host_wr = 1; host_sel_addr = 0; host_wdata = 8'h77;
    @(negedge clk);
    host_wr = 0;
    wait_rdy(k);
    chk("R6", "abort time in window", int'(k >= WD - 5 && k <= WD + 5), 1);
    chk("R6", "stat set", int'(stat_timeout), 1);
    chk("R6", "dstb_n after abort", int'(port_dstb_n), 1);
    chk("R6", "write_n after abort", int'(port_write_n), 1);
    repeat (3) @(negedge clk);
    chk("R7", "stat sticky", int'(stat_timeout), 1);
    stat_rd = 1;
    @(negedge clk);
    stat_rd = 0;
    chk("R7", "stat cleared", int'(stat_timeout), 0);

    // R6: stuck in strobe phase
    port_wait_n = 1'b0;
    repeat (4) @(negedge clk);
    host_rd = 1;
    @(negedge clk);
    host_rd = 0;
    repeat (20) @(negedge clk);
    chk("R6", "strobe held while stalled", int'(port_dstb_n), 0);
    wait_rdy(k);
    chk("R6", "abort from strobe", int'(k >= WD - 30 && k <= WD - 10), 1);
    chk("R6", "dstb_n released", int'(port_dstb_n), 1);
    chk("R6", "stat set again", int'(stat_timeout), 1);
    stat_rd = 1;
    @(negedge clk);
    stat_rd = 0;
    chk("R7", "stat cleared again", int'(stat_timeout), 0);

    // recovery after abort
    periph_en = 1;
    repeat (4) @(negedge clk);
    do_cyc(1, 0, 8'h99);
    repeat (10) @(negedge clk);
    done = 1;
    report();
  end
endmodule